// File: doc/BRIEF.md
# Predicated Register Execution Unit

This block executes one already-decoded instruction per clock against two register files: a file of general-purpose data registers and a smaller file of one-bit predicate registers. Every instruction names a guard predicate. When the guard reads true, the instruction's result is written at the next rising edge. When the guard reads false, the instruction is dropped, no register changes, and a `squashed` flag is raised for one cycle.

Two kinds of conditional code can be built from its operations. In the first kind, a comparison produces a predicate and a negation produces its complement, and the two arms of an if/else are issued under opposite guards. In the second kind, both arms are computed without a guard and the live result is then picked by a select or a conditional move, which reads a predicate as a data operand. Predicate register p0 always reads true, so a guard field of zero makes an instruction unconditional. Set and clear of a predicate ignore the guard, so predicates can always be initialised. A combinational debug port reads any register of either file.

Top module: `pred_exec_unit`

## Requirements
- R1: After a synchronous active-high reset, every general register reads 0, predicates p1 to p7 read 0, and `squashed` is low.
- R2: Predicate p0 always reads 1, and an instruction whose predicate destination is p0 changes no predicate.
- R3: When `in_valid` is high and the guard predicate reads 0, no register changes and `squashed` is high for the one cycle after that edge. Set (6) and clear (7) are never squashed.
- R4: ADD (op 1) writes rs1+rs2 and SUB (op 2) writes rs1-rs2 into rd, both modulo 2^32.
- R5: LDI (op 10) writes the 32-bit `in_imm` into rd.
- R6: SGT (op 3) writes the result of signed rs1>rs2 into predicate pd, and SLT (op 4) writes the result of signed rs1<rs2 into pd. No general register changes.
- R7: PNEG (op 5) writes the inverse of predicate ps into predicate pd.
- R8: PSET (op 6) writes 1 and PCLR (op 7) writes 0 into pd, whatever the guard reads.
- R9: SEL (op 8) writes rs1 into rd when predicate ps is 1, and writes rs2 into rd when ps is 0.
- R10: CMOV (op 9) writes rs1 into rd when predicate ps is 1, and leaves rd unchanged when ps is 0.
- R11: While `in_valid` is low, no register changes and `squashed` stays low.
- R12: Opcodes 0 and 11 to 15 change no register. They are still squashed when the guard reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode |
| in_guard | input | 3 | Guard predicate index |
| in_rd | input | 4 | General destination index |
| in_rs1 | input | 4 | First general source index |
| in_rs2 | input | 4 | Second general source index |
| in_pd | input | 3 | Predicate destination index |
| in_ps | input | 3 | Predicate operand index (PNEG, SEL, CMOV) |
| in_imm | input | 32 | Immediate for LDI |
| dbg_gaddr | input | 4 | Debug general register index |
| dbg_paddr | input | 3 | Debug predicate index |
| dbg_gdata | output | 32 | Debug general register value |
| dbg_pdata | output | 1 | Debug predicate value |
| squashed | output | 1 | Previous-cycle instruction was skipped by its guard |

## Verification
On every cycle the assertions check four things: a false guard freezes both files and sets `squashed`, a write aimed at p0 leaves the predicates alone, PSET always commits, and a CMOV with a false operand or an idle cycle leaves the data registers unchanged. The arithmetic values, the signed comparisons near the sign boundary, the choice a select makes, and the complete if/else sequences in both styles can only be shown by the bench scenarios. Those scenarios compare a behavioural model of both register files with the debug port after every instruction.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int unsigned XLEN_DEF  = 32;
    parameter int unsigned NGPR_DEF  = 16;
    parameter int unsigned NPRED_DEF = 8;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SGT  = 4'd3,
        OP_SLT  = 4'd4,
        OP_PNEG = 4'd5,
        OP_PSET = 4'd6,
        OP_PCLR = 4'd7,
        OP_SEL  = 4'd8,
        OP_CMOV = 4'd9,
        OP_LDI  = 4'd10
    } pxu_op_e;
endpackage

// File: rtl/pxu_guard.sv
module pxu_guard #(
    parameter int unsigned NPRED = 8,
    localparam int unsigned PW   = $clog2(NPRED)
) (
    input  logic [NPRED-1:0] pred_view,
    input  logic [3:0]       op,
    input  logic [PW-1:0]    guard_idx,
    input  logic [PW-1:0]    psrc_idx,
    output logic             guard_ok,
    output logic             psrc_val
);
    import pxu_pkg::*;

    logic exempt;

    always_comb begin
        exempt   = (op == OP_PSET) || (op == OP_PCLR);
        guard_ok = exempt || pred_view[guard_idx];
        psrc_val = pred_view[psrc_idx];
    end
endmodule

// File: rtl/pxu_alu.sv
module pxu_alu #(
    parameter int unsigned XLEN = 32
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] imm,
    input  logic            psrc,
    output logic            gwr_en,
    output logic [XLEN-1:0] gwr_data,
    output logic            pwr_en,
    output logic            pwr_val
);
    import pxu_pkg::*;

    always_comb begin
        gwr_en   = 1'b0;
        gwr_data = src_a;
        pwr_en   = 1'b0;
        pwr_val  = 1'b0;
        case (op)
            OP_ADD:  begin gwr_en = 1'b1; gwr_data = src_a + src_b; end
            OP_SUB:  begin gwr_en = 1'b1; gwr_data = src_a - src_b; end
            OP_LDI:  begin gwr_en = 1'b1; gwr_data = imm; end
            OP_SEL:  begin gwr_en = 1'b1; gwr_data = psrc ? src_a : src_b; end
            OP_CMOV: begin gwr_en = psrc; gwr_data = src_a; end
            OP_SGT:  begin pwr_en = 1'b1; pwr_val = $signed(src_a) > $signed(src_b); end
            OP_SLT:  begin pwr_en = 1'b1; pwr_val = $signed(src_a) < $signed(src_b); end
            OP_PNEG: begin pwr_en = 1'b1; pwr_val = ~psrc; end
            OP_PSET: begin pwr_en = 1'b1; pwr_val = 1'b1; end
            OP_PCLR: begin pwr_en = 1'b1; pwr_val = 1'b0; end
            default: ;
        endcase
    end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit #(
    parameter int unsigned XLEN  = pxu_pkg::XLEN_DEF,
    parameter int unsigned NGPR  = pxu_pkg::NGPR_DEF,
    parameter int unsigned NPRED = pxu_pkg::NPRED_DEF,
    localparam int unsigned GW   = $clog2(NGPR),
    localparam int unsigned PW   = $clog2(NPRED)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      in_op,
    input  logic [PW-1:0]   in_guard,
    input  logic [GW-1:0]   in_rd,
    input  logic [GW-1:0]   in_rs1,
    input  logic [GW-1:0]   in_rs2,
    input  logic [PW-1:0]   in_pd,
    input  logic [PW-1:0]   in_ps,
    input  logic [XLEN-1:0] in_imm,
    input  logic [GW-1:0]   dbg_gaddr,
    input  logic [PW-1:0]   dbg_paddr,
    output logic [XLEN-1:0] dbg_gdata,
    output logic            dbg_pdata,
    output logic            squashed
);
    import pxu_pkg::*;

    typedef struct packed {
        logic [NGPR-1:0][XLEN-1:0] gpr;
        logic [NPRED-1:1]          pred;
        logic                      squash;
    } state_t;

    state_t st_d, st_q;

    logic [NPRED-1:0] pred_view;
    logic             guard_ok, psrc_val;
    logic             gwr_en, pwr_en, pwr_val;
    logic [XLEN-1:0]  gwr_data;

    assign pred_view = {st_q.pred, 1'b1};

    pxu_guard #(.NPRED(NPRED)) u_guard (
        .pred_view (pred_view),
        .op        (in_op),
        .guard_idx (in_guard),
        .psrc_idx  (in_ps),
        .guard_ok  (guard_ok),
        .psrc_val  (psrc_val)
    );

    pxu_alu #(.XLEN(XLEN)) u_alu (
        .op       (in_op),
        .src_a    (st_q.gpr[in_rs1]),
        .src_b    (st_q.gpr[in_rs2]),
        .imm      (in_imm),
        .psrc     (psrc_val),
        .gwr_en   (gwr_en),
        .gwr_data (gwr_data),
        .pwr_en   (pwr_en),
        .pwr_val  (pwr_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.squash = 1'b0;
        if (in_valid) begin
            if (!guard_ok) begin
                st_d.squash = 1'b1;
            end else begin
                if (gwr_en) st_d.gpr[in_rd] = gwr_data;
                if (pwr_en && (in_pd != '0)) st_d.pred[in_pd] = pwr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dbg_gdata = st_q.gpr[dbg_gaddr];
    assign dbg_pdata = pred_view[dbg_paddr];
    assign squashed  = st_q.squash;

    // R3
    skip_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !guard_ok) |=> (squashed && st_q.gpr == $past(st_q.gpr)
                                     && st_q.pred == $past(st_q.pred)));

    // R2
    p0_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pd == '0) |=> (st_q.pred == $past(st_q.pred)));

    // R8
    pset_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_PSET && in_pd != '0) |=> (pred_view[$past(in_pd)] && !squashed));

    // R10
    cmov_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_CMOV && !psrc_val) |=> (st_q.gpr == $past(st_q.gpr)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> (!squashed && $stable(st_q.gpr) && $stable(st_q.pred)));
endmodule

// File: tb/tb_pred_exec_unit.sv
`timescale 1ns/1ps
module tb_pred_exec_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [2:0]  in_guard, in_pd, in_ps;
    logic [3:0]  in_rd, in_rs1, in_rs2;
    logic [31:0] in_imm;
    logic [3:0]  dbg_gaddr;
    logic [2:0]  dbg_paddr;
    logic [31:0] dbg_gdata;
    logic        dbg_pdata, squashed;

    always #4 clk = ~clk;

    pred_exec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_guard(in_guard), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_pd(in_pd), .in_ps(in_ps), .in_imm(in_imm),
        .dbg_gaddr(dbg_gaddr), .dbg_paddr(dbg_paddr),
        .dbg_gdata(dbg_gdata), .dbg_pdata(dbg_pdata), .squashed(squashed)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [31:0] mg [16];
    bit          mp [8];
    bit          msq;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input bit skip);
        if (skip) return "R3";
        case (op)
            1, 2:    return "R4";
            10:      return "R5";
            3, 4:    return "R6";
            5:       return "R7";
            6, 7:    return "R8";
            8:       return "R9";
            9:       return "R10";
            default: return "R12";
        endcase
    endfunction

    // model one instruction, apply it, check rd, pd and squashed after the edge
    task automatic issue(input int op, input int g, input int rd, input int a,
                         input int b, input int pd, input int ps, input logic [31:0] imm);
        bit ok, pv;
        string t;
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'(op); in_guard = 3'(g); in_rd = 4'(rd);
        in_rs1 = 4'(a); in_rs2 = 4'(b); in_pd = 3'(pd); in_ps = 3'(ps); in_imm = imm;
        dbg_gaddr = 4'(rd); dbg_paddr = 3'(pd);
        ok = (op == 6 || op == 7) ? 1'b1 : mp[g];
        pv = mp[ps];
        t  = tag_of(op, !ok);
        msq = !ok;
        if (ok) begin
            case (op)
                1:  mg[rd] = mg[a] + mg[b];
                2:  mg[rd] = mg[a] - mg[b];
                10: mg[rd] = imm;
                8:  mg[rd] = pv ? mg[a] : mg[b];
                9:  if (pv) mg[rd] = mg[a];
                3:  if (pd != 0) mp[pd] = $signed(mg[a]) > $signed(mg[b]);
                4:  if (pd != 0) mp[pd] = $signed(mg[a]) < $signed(mg[b]);
                5:  if (pd != 0) mp[pd] = !pv;
                6:  if (pd != 0) mp[pd] = 1'b1;
                7:  if (pd != 0) mp[pd] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk(t, "squashed", {31'd0, squashed}, {31'd0, msq});
        chk(t, "gpr[rd]", dbg_gdata, mg[rd]);
        chk((pd == 0) ? "R2" : t, "pred[pd]", {31'd0, dbg_pdata}, {31'd0, mp[pd]});
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 4'd1; in_guard = 3'd0; in_rd = 4'd3; in_pd = 3'd3;
        msq = 1'b0;
        @(posedge clk);
        #1;
        chk(req, "squashed idle", {31'd0, squashed}, 32'd0);
    endtask

    task automatic sweep(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            dbg_gaddr = 4'(i); #0.2;
            chk(req, $sformatf("sweep gpr[%0d]", i), dbg_gdata, mg[i]);
        end
        for (int i = 0; i < 8; i++) begin
            dbg_paddr = 3'(i); #0.2;
            chk(req, $sformatf("sweep pred[%0d]", i), {31'd0, dbg_pdata}, {31'd0, mp[i]});
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mg[i] = '0;
        for (int i = 0; i < 8; i++) mp[i] = (i == 0);
        msq = 1'b0;
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_guard = '0; in_rd = '0;
        in_rs1 = '0; in_rs2 = '0; in_pd = '0; in_ps = '0; in_imm = '0;
        dbg_gaddr = '0; dbg_paddr = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: fill some state, then reset again and check it cleared
        rst = 1'b0;
        issue(10, 0, 5, 0, 0, 0, 0, 32'hDEAD_BEEF);
        issue(6, 0, 0, 0, 0, 4, 0, 0);
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 16; i++) mg[i] = '0;
        for (int i = 0; i < 8; i++) mp[i] = (i == 0);
        chk("R1", "squashed reset", {31'd0, squashed}, 32'd0);
        @(negedge clk); rst = 1'b0;
        sweep("R1");

        // R5 load immediates, R4 add/sub with wrap
        issue(10, 0, 1, 0, 0, 0, 0, 32'd5);
        issue(10, 0, 2, 0, 0, 0, 0, 32'd9);
        issue(10, 0, 3, 0, 0, 0, 0, 32'hFFFF_FFFF);
        issue(1, 0, 4, 3, 1, 0, 0, 0);
        issue(2, 0, 6, 1, 2, 0, 0, 0);
        // R6 signed compares, including negative against positive
        issue(3, 0, 0, 1, 2, 1, 0, 0);
        issue(4, 0, 0, 1, 2, 2, 0, 0);
        issue(3, 0, 0, 1, 3, 3, 0, 0);
        issue(4, 0, 0, 3, 1, 4, 0, 0);
        // R2 writes to p0 have no effect
        issue(7, 0, 0, 0, 0, 0, 0, 0);
        issue(5, 0, 0, 0, 0, 0, 0, 0);
        // R7 negation, full-predication if/else: exactly one arm commits (R3)
        issue(3, 0, 0, 1, 2, 5, 0, 0);
        issue(5, 0, 0, 0, 0, 6, 5, 0);
        issue(1, 5, 2, 1, 2, 0, 0, 0);
        issue(2, 6, 2, 1, 2, 0, 0, 0);
        // R8 set/clear ignore a false guard
        issue(7, 5, 0, 0, 0, 4, 0, 0);
        issue(6, 5, 0, 0, 0, 7, 0, 0);
        issue(6, 4, 0, 0, 0, 5, 0, 0);
        // partial predication: compute both arms, pick with SEL (R9) and CMOV (R10)
        issue(1, 0, 7, 1, 2, 0, 0, 0);
        issue(2, 0, 8, 1, 2, 0, 0, 0);
        issue(8, 0, 9, 7, 8, 0, 5, 0);
        issue(8, 0, 10, 7, 8, 0, 4, 0);
        issue(9, 0, 11, 7, 0, 0, 5, 0);
        issue(9, 0, 8, 7, 0, 0, 4, 0);
        // R12 unknown and nop opcodes, both guarded true and false
        issue(12, 0, 1, 2, 3, 1, 0, 32'h1234);
        issue(0, 0, 2, 2, 3, 2, 0, 0);
        issue(15, 4, 3, 2, 3, 3, 0, 0);
        // R11 idle cycles
        idle("R11");
        idle("R11");
        sweep("R11");

        for (int n = 0; n < 600; n++) begin
            int op;
            op = (($urandom_range(0, 9) == 0) ? $urandom_range(11, 15) : $urandom_range(0, 10));
            issue(op, $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 15),
                  $urandom_range(0, 15), $urandom_range(0, 7), $urandom_range(0, 7), $urandom);
            if ((n % 50) == 49) idle("R11");
        end
        sweep("R3");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule